// File: doc/BRIEF.md
# Cubic Spline Waveform Interpolator

This block drives one slowly varying waveform parameter, such as a DC level or an amplitude envelope, from a compact polynomial description. A single write loads a record of one to four signed terms: a starting level, a per-sample slope, a curvature and a jerk. Starting with the next clock, the block produces one new sample on every cycle. It does this with a chain of forward-difference accumulators: each accumulator adds in the one above it, using the values held before that clock's update.

Each term is one order higher than the last and carries 16 more fraction bits, so a cubic ramp between two levels is resolved finely over long segments. A new write takes effect at once and discards whatever segment was running. The current sample is repeated on every lane of a two-lane parallel sample bus. Terms above the count given with the write are treated as zero, so a level-only write produces a flat output.

Top module: `spline_segment_gen`

## Requirements
- R1: The record bus packs its fields from bit 0 upward. Level is bits 15:0, slope is bits 47:16, curvature is bits 95:48 and jerk is bits 159:96. Each field is a two's-complement number.
- R2: `wr_terms_m1` gives the number of terms minus one (0 means level only, 3 means all four). Fields above that count are read as zero, whatever the bus holds in those bit positions.
- R3: On every clock with no write, the accumulators update together from their pre-update values. The level accumulator adds the slope accumulator, the slope accumulator adds the curvature accumulator, and the curvature accumulator adds the jerk accumulator. At each step the addend is shifted right by 16 bits, with its sign kept.
- R4: A write strobe is accepted on any cycle and replaces the running segment. The first sample of the new segment appears on the bus after the second rising edge counted from the edge that samples the strobe, and it equals the written level.
- R5: A level-only write holds the output constant at that level. A level-only write of 0 holds the output at 0.
- R6: The slope has 16 fraction bits below the sample LSB. Sample i of a two-term segment equals level + floor(i × slope / 65536), taken modulo 2^16.
- R7: Every lane of `sample_bus` carries the same sample in every cycle. Lane 0 occupies bits 15:0.
- R8: `busy` is always low.
- R9: While reset is asserted, and after it is released with no write, every lane reads 0.
- R10: Negative fields are sign-extended into their accumulators. A slope field of all ones (−1) next to a level of 0 gives 0 followed by 0xFFFF on every later sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Record write strobe |
| wr_terms_m1 | input | 2 | Number of valid terms minus one |
| wr_data | input | 160 | Packed coefficient record |
| busy | output | 1 | Write-not-accepted flag, always 0 |
| sample_bus | output | 32 | Two 16-bit sample lanes, lane 0 in the low half |

## Verification
A wrong value left in any accumulator reaches the bus in a predictable number of cycles. A bad level shows up on the first sample after the write. A bad slope shows up on the second sample. A bad curvature or jerk shows up one or two samples later still, as a growing error in a quadratic or cubic sequence. The scoreboard therefore compares every sample of each segment from the first one on, so that an error of any order is caught within a few cycles of the write. A term that leaks through from above the term count shows up as a drift on a segment that should stay flat or linear.

// File: rtl/spline_seg_pkg.sv
package spline_seg_pkg;

    // Width of the coefficient field of a given order.
    function automatic int term_width(int sample_w, int frac_w, int k);
        return sample_w + k * frac_w;
    endfunction

    // Bit position where a field starts in the packed record.
    function automatic int term_lsb(int sample_w, int frac_w, int k);
        int pos;
        pos = 0;
        for (int i = 0; i < k; i++) begin
            pos += term_width(sample_w, frac_w, i);
        end
        return pos;
    endfunction

    // Accumulator width: the field plus the fraction bits of the next order.
    function automatic int acc_width(int sample_w, int frac_w, int k);
        return term_width(sample_w, frac_w, k) + frac_w;
    endfunction

endpackage

// File: rtl/spline_rec_unpack.sv
module spline_rec_unpack
    import spline_seg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 16,
    parameter int ORDERS   = 4,
    localparam int REC_W   = term_lsb(SAMPLE_W, FRAC_W, ORDERS),
    localparam int TSW     = (ORDERS > 1) ? $clog2(ORDERS) : 1,
    localparam int LOAD_W  = acc_width(SAMPLE_W, FRAC_W, ORDERS - 1)
) (
    input  logic [REC_W-1:0]  rec,
    input  logic [TSW-1:0]    terms_m1,
    output logic [LOAD_W-1:0] load_val [ORDERS]
);

    for (genvar k = 0; k < ORDERS; k++) begin : g_field
        localparam int LSB = term_lsb(SAMPLE_W, FRAC_W, k);
        localparam int W   = term_width(SAMPLE_W, FRAC_W, k);

        logic signed [W-1:0]      raw;
        logic signed [LOAD_W-1:0] wide;

        assign raw = rec[LSB +: W];

        always_comb begin
            wide = LOAD_W'(raw);
            if (32'(terms_m1) >= k) begin
                load_val[k] = wide <<< FRAC_W;
            end else begin
                load_val[k] = '0;
            end
        end
    end

endmodule

// File: rtl/spline_acc_stage.sv
module spline_acc_stage #(
    parameter int ACC_W  = 32,
    parameter int FRAC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.acc = load_val;
        end else begin
            st_d.acc = st_q.acc + addend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
        end
    end

    // R4: a write replaces the accumulator with the loaded term
    a_r4_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(load)) |-> (acc == $past(load_val)));

    // R3: without a write the accumulator advances by its addend
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(load)) |-> (acc == ACC_W'($past(acc) + $past(addend))));

    initial begin
        if (FRAC_W >= ACC_W) $error("fraction width must be below accumulator width");
    end

endmodule

// File: rtl/spline_lane_out.sv
module spline_lane_out #(
    parameter int SAMPLE_W = 16,
    parameter int LANES    = 2,
    localparam int BUS_W   = SAMPLE_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [BUS_W-1:0]    bus
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d        = ln_q;
        ln_d.sample = sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bus[l*SAMPLE_W +: SAMPLE_W] = ln_q.sample;

        // R7: each lane presents the sample computed one cycle earlier
        a_r7_lane_follows: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok_q |-> (bus[l*SAMPLE_W +: SAMPLE_W] == $past(sample)));
    end

endmodule

// File: rtl/spline_segment_gen.sv
module spline_segment_gen
    import spline_seg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FRAC_W   = 16,
    parameter int ORDERS   = 4,
    parameter int LANES    = 2,
    localparam int REC_W   = term_lsb(SAMPLE_W, FRAC_W, ORDERS),
    localparam int TSW     = (ORDERS > 1) ? $clog2(ORDERS) : 1,
    localparam int BUS_W   = SAMPLE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [TSW-1:0]   wr_terms_m1,
    input  logic [REC_W-1:0] wr_data,
    output logic             busy,
    output logic [BUS_W-1:0] sample_bus
);

    localparam int LOAD_W = acc_width(SAMPLE_W, FRAC_W, ORDERS - 1);

    logic [LOAD_W-1:0]   load_val [ORDERS];
    logic [LOAD_W-1:0]   acc_all  [ORDERS];
    logic [SAMPLE_W-1:0] cur_sample;

    spline_rec_unpack #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_W   (FRAC_W),
        .ORDERS   (ORDERS)
    ) u_unpack (
        .rec      (wr_data),
        .terms_m1 (wr_terms_m1),
        .load_val (load_val)
    );

    for (genvar k = 0; k < ORDERS; k++) begin : g_ord
        localparam int AW = acc_width(SAMPLE_W, FRAC_W, k);

        logic [AW-1:0] acc;
        logic [AW-1:0] addend;

        if (k < ORDERS - 1) begin : g_chain
            assign addend = acc_all[k+1][FRAC_W +: AW];
        end else begin : g_top
            assign addend = '0;
        end

        spline_acc_stage #(
            .ACC_W  (AW),
            .FRAC_W (FRAC_W)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_stb),
            .load_val (load_val[k][AW-1:0]),
            .addend   (addend),
            .acc      (acc)
        );

        assign acc_all[k] = LOAD_W'($signed(acc));
    end

    assign cur_sample = acc_all[0][FRAC_W +: SAMPLE_W];

    spline_lane_out #(
        .SAMPLE_W (SAMPLE_W),
        .LANES    (LANES)
    ) u_lanes (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (cur_sample),
        .bus    (sample_bus)
    );

    // Every cycle accepts a write, so the flag never rises.
    assign busy = 1'b0;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R4: two edges after a write, lane 0 shows the written level
    a_r4_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(wr_stb, 2) && !$past(wr_stb))
        |-> (sample_bus[SAMPLE_W-1:0] == $past(wr_data[SAMPLE_W-1:0], 2)));

    // R5: a level-only segment keeps the bus unchanged
    a_r5_hold_constant: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(wr_stb, 2) && ($past(wr_terms_m1, 2) == '0)
         && !$past(wr_stb) && !wr_stb)
        |=> $stable(sample_bus));

    // R8: a write is never refused
    a_r8_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !busy);

endmodule

// File: tb/spline_segment_gen_tb.sv
module spline_segment_gen_tb;

    localparam int SW = 16;
    localparam int LN = 2;
    localparam int RW = 160;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_stb;
    logic [1:0]    wr_terms_m1;
    logic [RW-1:0] wr_data;
    logic          busy;
    logic [LN*SW-1:0] sample_bus;

    always #10 clk = ~clk;

    spline_segment_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_terms_m1 (wr_terms_m1),
        .wr_data     (wr_data),
        .busy        (busy),
        .sample_bus  (sample_bus)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [SW-1:0] val;
        string         tag;
    } item_t;

    item_t exp_q[$];
    int    skip   = 0;
    bit    mon_on = 1'b0;

    task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Monitor: samples a quarter period after each rising edge.
    always begin
        @(posedge clk);
        #5;
        if (mon_on) begin
            if (skip > 0) begin
                skip--;
            end else if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, sample_bus[SW-1:0], it.val);
                for (int l = 1; l < LN; l++) begin
                    check("R7", sample_bus[l*SW +: SW], sample_bus[SW-1:0]);
                end
            end
        end
    end

    function automatic logic [RW-1:0] pack(input logic [15:0] v, input logic [31:0] s,
                                           input logic [47:0] c, input logic [63:0] j);
        logic [RW-1:0] r;
        r = {j, c, s, v};
        return r;
    endfunction

    // Driver: models the requirement recurrence, queues the samples, issues the write.
    task automatic segment(input logic [1:0] terms_m1, input logic [RW-1:0] data,
                           input int n, input string tag);
        logic signed [127:0] a [4];
        logic signed [127:0] f [4];
        f[0] = 128'($signed(data[15:0]));
        f[1] = 128'($signed(data[47:16]));
        f[2] = 128'($signed(data[95:48]));
        f[3] = 128'($signed(data[159:96]));
        for (int k = 0; k < 4; k++) begin
            a[k] = (k <= int'(terms_m1)) ? (f[k] <<< 16) : 128'sd0;
        end
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.val = a[0][31:16];
            it.tag = tag;
            exp_q.push_back(it);
            a[0] = a[0] + (a[1] >>> 16);
            a[1] = a[1] + (a[2] >>> 16);
            a[2] = a[2] + (a[3] >>> 16);
        end
        skip        = 1;
        wr_stb      = 1'b1;
        wr_terms_m1 = terms_m1;
        wr_data     = data;
        n_tests++;
        if (busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: actual busy %b expected 0", busy);
        end
        @(negedge clk);
        wr_stb  = 1'b0;
        wr_data = {RW{1'b1}};
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        wr_stb      = 1'b0;
        wr_terms_m1 = 2'd0;
        wr_data     = '0;
        repeat (3) @(negedge clk);
        check("R9", sample_bus[SW-1:0], 16'h0000);
        check("R9", sample_bus[SW +: SW], 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", sample_bus[SW-1:0], 16'h0000);
        check("R8", {15'd0, busy}, 16'h0000);
        mon_on = 1'b1;

        // R6: integer slope, level 100 stepping by 10
        segment(2'd1, pack(16'd100, 32'd10 << 16, 48'd0, 64'd0), 12, "R6");
        // R6: quarter-LSB slope accumulates its fraction
        segment(2'd1, pack(16'd50, 32'h0000_4000, 48'd0, 64'd0), 10, "R6");
        // R2: curvature and jerk bits present but outside the term count
        segment(2'd1, pack(16'd7, 32'd3 << 16, 48'h7abc_dead_beef, 64'h1234_5678_9abc_def0),
                10, "R2");
        // R5 / R2: level only, upper fields full of junk
        segment(2'd0, pack(16'h1234, 32'hffff_ffff, 48'h0f0f_0f0f_0f0f, 64'h5555_aaaa_5555_aaaa),
                8, "R5");
        // R5: level-only write of zero holds zero
        segment(2'd0, pack(16'd0, 32'h0ace_0000, 48'd0, 64'd0), 6, "R5");
        // R10: negative integer slope ramps down through zero
        segment(2'd1, pack(16'd20, 32'hfffd_0000, 48'd0, 64'd0), 12, "R10");
        // R10: slope of -1 next to a zero level
        segment(2'd1, pack(16'd0, 32'hffff_ffff, 48'd0, 64'd0), 5, "R10");
        // R3: quadratic, one LSB per step squared
        segment(2'd2, pack(16'd10, 32'd0, 48'h0001_0000_0000, 64'd0), 12, "R3");
        // R1 / R3: full cubic record with signed terms
        segment(2'd3, pack(16'hff38, 32'h0001_8000, 48'hffff_c000_0000,
                           64'h0000_1000_0000_0000), 16, "R1");
        // R4: replace a long ramp after a few samples with a new one
        segment(2'd1, pack(16'd1000, 32'd5 << 16, 48'd0, 64'd0), 4, "R4");
        segment(2'd1, pack(16'd3, 32'd1 << 16, 48'd0, 64'd0), 6, "R4");
        // R4: back-to-back writes, the second one wins
        @(negedge clk);
        wr_stb      = 1'b1;
        wr_terms_m1 = 2'd0;
        wr_data     = pack(16'h7777, 32'd0, 48'd0, 64'd0);
        segment(2'd0, pack(16'h0042, 32'd0, 48'd0, 64'd0), 4, "R4");

        mon_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule